// File: doc/BRIEF.md
# Memory Stage Access Unit

This unit is the data-memory step of a single-cycle processor datapath. Each cycle it takes the operation code of the current instruction, the ALU result, the first register operand and the next-instruction address. From these it works out whether data memory is read or written, which address is used and which value is stored. It holds the data memory itself, a byte array of parameterized size. A 64-bit word is read from that array in the same cycle. A 64-bit word is written to it at the rising clock edge.

Stack operations need different routing. Pop and return read at the stack pointer value from before the update. Call stores the return address rather than a register value. An access whose eight bytes do not all fall inside the array raises a fault flag. A faulting write leaves memory untouched, and a faulting read returns zero.

All pins are plain and sampled every cycle. A new operation is presented each clock with no handshake, and the stage can never stall its neighbours.

Top module: `memstage_unit`

## Requirements
- R1: The read enable is high exactly for op codes 4'h5 (load), 4'hB (pop) and 4'h9 (return). The write enable is high exactly for op codes 4'h4 (store), 4'hA (push) and 4'h8 (call). Both enables are low for all other codes.
- R2: The memory address equals the ALU result, except for pop (4'hB) and return (4'h9), where it equals the first register operand.
- R3: The write data equals the first register operand, except for call (4'h8), where it equals the next-instruction address.
- R4: Read data appears combinationally in the same cycle as the address. A write updates memory at the rising edge ending that cycle, so a read in the next cycle returns the new word.
- R5: When either enable is high and the address is greater than DEPTH_BYTES-8, the fault flag is high, no byte of memory is written and the read data is zero. With both enables low the fault flag is low.
- R6: Words are little-endian. The byte at the address holds bits 7:0 and the byte at address+7 holds bits 63:56. Any byte alignment is allowed.
- R7: The read data output is zero whenever the read enable is low.
- R8: After reset every memory byte reads as zero.
- R9: An operation that enables no access leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears memory |
| op_code | input | 4 | Operation code of the current instruction |
| alu_result | input | 64 | ALU output (default address) |
| reg_a_val | input | 64 | First register operand (default store data, stack address for pop/return) |
| next_pc | input | 64 | Address of the next instruction (store data for call) |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_addr | output | 64 | Selected byte address |
| mem_wdata | output | 64 | Selected store data |
| mem_rdata | output | 64 | Word read from memory, zero when not reading or faulting |
| addr_fault | output | 1 | Address out of range on an enabled access |

## Verification
The hardest situation to reach is the fault boundary. An access at exactly DEPTH_BYTES-8 must succeed and one a single byte higher must fail. The failing write must leave every byte intact, including the in-range bytes it partly overlaps. Random addresses almost never land there, so directed steps store at the last legal word, try a store one byte higher, and read the last word back. Random steps also draw addresses near and beyond the top of the array, and through the stack operand as well as the ALU result. Unaligned loads after known stores expose the byte ordering.

// File: rtl/memstage_pkg.sv
package memstage_pkg;
  localparam int WORD_W  = 64;
  localparam int LANES   = WORD_W / 8;
  localparam int OP_W    = 4;

  localparam logic [OP_W-1:0] OP_STORE = 4'h4;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [OP_W-1:0] OP_CALL  = 4'h8;
  localparam logic [OP_W-1:0] OP_RET   = 4'h9;
  localparam logic [OP_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [OP_W-1:0] OP_POP   = 4'hB;
endpackage

// File: rtl/memstage_ctl.sv
module memstage_ctl
  import memstage_pkg::*;
(
  input  logic [OP_W-1:0]   op_code,
  input  logic [WORD_W-1:0] alu_result,
  input  logic [WORD_W-1:0] reg_a_val,
  input  logic [WORD_W-1:0] next_pc,
  output logic              rd_en,
  output logic              wr_en,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  always_comb begin
    rd_en = 1'b0;
    wr_en = 1'b0;
    addr  = alu_result;
    wdata = reg_a_val;
    case (op_code)
      OP_LOAD:  rd_en = 1'b1;
      OP_POP,
      OP_RET: begin
        rd_en = 1'b1;
        addr  = reg_a_val;
      end
      OP_STORE,
      OP_PUSH:  wr_en = 1'b1;
      OP_CALL: begin
        wr_en = 1'b1;
        wdata = next_pc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/memstage_bounds.sv
module memstage_bounds
  import memstage_pkg::*;
#(
  parameter int DEPTH_BYTES = 256
) (
  input  logic              access,
  input  logic [WORD_W-1:0] addr,
  output logic              fault
);
  localparam logic [WORD_W-1:0] LAST_OK = WORD_W'(DEPTH_BYTES - LANES);

  always_comb fault = access && (addr > LAST_OK);
endmodule

// File: rtl/memstage_ram.sv
module memstage_ram
  import memstage_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  localparam int IDXW = $clog2(DEPTH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDXW-1:0]   base,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [7:0] mem [DEPTH_BYTES];
  logic [IDXW-1:0] lane_idx [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_idx[j] = base + IDXW'(j);
    assign rdata[8*j +: 8] = mem[lane_idx[j]];

    // R4, R6: a committed write leaves its byte j at address base+j
    a_r6_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(lane_idx[j])] == $past(wdata[8*j +: 8]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH_BYTES; i++) mem[i] <= 8'h00;
    end else if (we) begin
      for (int j = 0; j < LANES; j++) mem[lane_idx[j]] <= wdata[8*j +: 8];
    end
  end
endmodule

// File: rtl/memstage_unit.sv
module memstage_unit
  import memstage_pkg::*;
#(
  parameter int DEPTH_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic [63:0]       alu_result,
  input  logic [63:0]       reg_a_val,
  input  logic [63:0]       next_pc,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [63:0]       mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [63:0]       mem_rdata,
  output logic              addr_fault
);
  localparam int IDXW = $clog2(DEPTH_BYTES);

  logic [WORD_W-1:0] raw_rdata;

  memstage_ctl u_ctl (
    .op_code    (op_code),
    .alu_result (alu_result),
    .reg_a_val  (reg_a_val),
    .next_pc    (next_pc),
    .rd_en      (mem_rd_en),
    .wr_en      (mem_wr_en),
    .addr       (mem_addr),
    .wdata      (mem_wdata)
  );

  memstage_bounds #(.DEPTH_BYTES(DEPTH_BYTES)) u_bounds (
    .access (mem_rd_en | mem_wr_en),
    .addr   (mem_addr),
    .fault  (addr_fault)
  );

  memstage_ram #(.DEPTH_BYTES(DEPTH_BYTES)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_wr_en & ~addr_fault),
    .base  (mem_addr[IDXW-1:0]),
    .wdata (mem_wdata),
    .rdata (raw_rdata)
  );

  assign mem_rdata = (mem_rd_en && !addr_fault) ? raw_rdata : '0;

  // R5: the fault flag only rises on an enabled access
  a_r5_fault_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |-> (mem_rd_en || mem_wr_en));
  // R5: a faulting access returns zero
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |-> mem_rdata == '0);
  // R7: no read, no data
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |-> mem_rdata == '0);
  // R1: a single operation never both reads and writes
  a_r1_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/memstage_unit_tb_top.sv
`timescale 1ns/1ps
module memstage_unit_tb_top;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  op_code = 4'h1;
  logic [63:0] alu_result = '0, reg_a_val = '0, next_pc = '0;
  logic mem_rd_en, mem_wr_en, addr_fault;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  memstage_unit #(.DEPTH_BYTES(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .alu_result(alu_result),
    .reg_a_val(reg_a_val), .next_pc(next_pc), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .addr_fault(addr_fault));

  function automatic bit f_rd(logic [3:0] op);
    return op == 4'h5 || op == 4'hB || op == 4'h9;
  endfunction
  function automatic bit f_wr(logic [3:0] op);
    return op == 4'h4 || op == 4'hA || op == 4'h8;
  endfunction
  function automatic logic [63:0] f_addr(logic [3:0] op, logic [63:0] e, logic [63:0] a);
    return (op == 4'hB || op == 4'h9) ? a : e;
  endfunction
  function automatic logic [63:0] f_data(logic [3:0] op, logic [63:0] a, logic [63:0] p);
    return (op == 4'h8) ? p : a;
  endfunction
  function automatic bit f_fault(logic [3:0] op, logic [63:0] ad);
    return (f_rd(op) || f_wr(op)) && (ad > 64'(DEPTH - 8));
  endfunction
  function automatic logic [63:0] f_read(logic [63:0] ad);
    logic [63:0] w = '0;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = model[int'(ad) + j];
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one operation at the falling edge, check, then commit on rising edge.
  task automatic step(logic [3:0] op, logic [63:0] e, logic [63:0] a, logic [63:0] p);
    logic [63:0] ad;
    bit flt;
    @(negedge clk);
    op_code = op; alu_result = e; reg_a_val = a; next_pc = p;
    #1;
    ad  = f_addr(op, e, a);
    flt = f_fault(op, ad);
    chk("R1 rd_en", 64'(mem_rd_en), 64'(f_rd(op)));
    chk("R1 wr_en", 64'(mem_wr_en), 64'(f_wr(op)));
    chk("R2 addr", mem_addr, ad);
    chk("R3 wdata", mem_wdata, f_data(op, a, p));
    chk("R5 fault", 64'(addr_fault), 64'(flt));
    if (f_rd(op) && !flt) chk("R4/R6 rdata", mem_rdata, f_read(ad));
    else chk("R5/R7 rdata zero", mem_rdata, '0);
    @(posedge clk);
    if (f_wr(op) && !flt)
      for (int j = 0; j < 8; j++) model[int'(ad) + j] = f_data(op, a, p)[8*j +: 8];
  endtask

  function automatic logic [63:0] rnd_addr();
    int sel = $urandom_range(0, 9);
    if (sel < 7) return 64'($urandom_range(0, DEPTH - 8));
    if (sel < 9) return 64'($urandom_range(DEPTH - 7, DEPTH + 16));
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8: memory cleared by reset
    step(4'h5, 64'd0, 0, 0);
    step(4'h5, 64'(DEPTH - 8), 0, 0);
    // R6: byte order and unaligned read
    step(4'h4, 64'd8, 64'h8877_6655_4433_2211, 0);
    step(4'h5, 64'd9, 0, 0);
    // R2/R3: push, call, then pop/return from the old stack pointer
    step(4'hA, 64'd32, 64'hDEAD_BEEF_0000_0001, 0);
    step(4'h8, 64'd40, 64'h0, 64'h0000_0000_0000_0ABC);
    step(4'hB, 64'd999, 64'd32, 0);
    step(4'h9, 64'd999, 64'd40, 0);
    // R5: last legal word, one byte past it, readback unchanged
    step(4'h4, 64'(DEPTH - 8), 64'hA5A5_A5A5_5A5A_5A5A, 0);
    step(4'h4, 64'(DEPTH - 7), 64'hFFFF_FFFF_FFFF_FFFF, 0);
    step(4'h5, 64'(DEPTH - 8), 0, 0);
    step(4'hB, 0, 64'hFFFF_FFFF_FFFF_FFF8, 0);
    // R9: non-memory op with in-range values, then readback
    step(4'h6, 64'd8, 64'h1, 64'h2);
    step(4'h5, 64'd8, 0, 0);
    for (int n = 0; n < 800; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      step(op, rnd_addr(), ($urandom_range(0, 1) == 1) ? rnd_addr() : {$urandom, $urandom},
           {$urandom, $urandom});
    end
    for (int k = 0; k < DEPTH; k += 8) step(4'h5, 64'(k), 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule